// File: doc/BRIEF.md
# Multi-mode timer/event counter

An up-counting timer whose behaviour is picked by a control byte. It can count edges on an external input or ticks of an internal divided clock. It can also measure how long an external pulse lasts. The counter starts from a software-loaded preload value. It reloads that value when it wraps past all ones, and it then raises a sticky overflow flag that also drives an interrupt line. Software reaches the block through a small register port. The port has a 2-bit address, a write strobe, write data and a combinational read-data bus.

A build parameter selects one of two clock variants. The prescaler variant divides the system clock by a power of two from 1 to 128. The source-select variant offers two choices: the system clock divided by 4, or a low-frequency tick that arrives as a one-cycle enable pulse. The external input passes through a two-flop synchronizer, and its edges are found in the system clock domain.

Register map (address: content): 0 is control, 1 is preload, 2 is count (read only), and 3 is status (bit 0 is the overflow flag).

Top module: `multimode_timer`

## Requirements
- R1: After reset, control, preload, count and the overflow flag all read 0, and `ovfIrq` is low.
- R2: Control bit fields are: [1:0] mode, [2] edge select, [3] run, and [6:4] prescaler code (prescaler variant) or [4] clock source (source-select variant). Bits outside the variant's fields read back as 0. A write of 0xFF reads back 0x7F in the prescaler variant and 0x1F in the source-select variant.
- R3: When run goes from 0 to 1, the count is loaded from the preload register.
- R4: Timer mode (mode 2'b10) with prescaler code n adds floor(M/2^n) to the count over M whole cycles that follow the load cycle.
- R5: In the source-select variant, timer mode counts the system clock divided by 4 when the source bit is 0. When the source bit is 1, it counts one step per `lfTick` pulse.
- R6: Event mode (mode 2'b01) counts rising edges of `extIn` when edge select is 0 and falling edges when it is 1.
- R7: The count does not change while run is 0, and it does not change in mode 2'b00.
- R8: Pulse-width mode (mode 2'b11) with edge select 1 counts internal ticks from a rising edge until the next falling edge. With prescaler code 0, the held result is the high time in cycles.
- R9: Pulse-width mode with edge select 0 counts from a falling edge until the next rising edge.
- R10: Once a pulse-width measurement stops, the count holds and further pulses are ignored. A new measurement is armed only by clearing run and then setting it again.
- R11: An increment from all ones reloads the preload value and sets the sticky overflow flag, which drives `ovfIrq`.
- R12: Writing status with bit 0 set clears the overflow flag. Writing status with bit 0 clear leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 preload, 2 count, 3 status) |
| wData | input | 16 | Write data |
| rData | output | 16 | Read data for `addr`, combinational |
| extIn | input | 1 | Asynchronous external event / pulse input |
| lfTick | input | 1 | One-cycle low-frequency tick enable |
| ovfIrq | output | 1 | Sticky overflow flag |

## Verification
The assertions take two things for granted. Each register write lasts exactly one cycle of `wrEn`. `extIn` is treated as an arbitrary asynchronous level, so every edge reaches the counter only through the synchronizer. The stimulus changes `extIn` and `lfTick` only on falling clock edges, and it keeps each external level for at least one full cycle, so no edge is lost in synchronization. It also clears run before it changes the preload or the mode. As a result, every expected count follows from cycle arithmetic on the write times and the pulse lengths.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'b00,
    MODE_EVENT  = 2'b01,
    MODE_TIMER  = 2'b10,
    MODE_PWIDTH = 2'b11
  } tmrMode_e;

  typedef enum logic [1:0] {
    PW_ARM  = 2'b00,
    PW_MEAS = 2'b01,
    PW_DONE = 2'b10
  } pwState_e;

  typedef struct packed {
    logic load;
    logic inc;
    logic clrFlag;
  } dpStrobe_t;

  localparam logic [1:0] ADDR_CTRL    = 2'd0;
  localparam logic [1:0] ADDR_PRELOAD = 2'd1;
  localparam logic [1:0] ADDR_COUNT   = 2'd2;
  localparam logic [1:0] ADDR_STATUS  = 2'd3;

  localparam int CTRL_RUN_BIT  = 3;
  localparam int CTRL_EDGE_BIT = 2;
  localparam int CTRL_CFG_LSB  = 4;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseOut,
  output logic fallOut
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], asyncIn};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign riseOut = syncQ[SYNC_STAGES-1] & ~prevQ;
  assign fallOut = ~syncQ[SYNC_STAGES-1] & prevQ;

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter bit USE_PRESCALER = 1'b1,
  parameter int PSC_W         = 3,
  parameter int FIXED_DIV_LOG = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic [PSC_W-1:0] cfg,
  input  logic             lfTick,
  output logic             tick
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] divQ;
  logic [DIV_W-1:0] divMask;
  logic             divHit;

  always_ff @(posedge clk) begin
    if (!rstN || clear) divQ <= '0;
    else                divQ <= divQ + 1'b1;
  end

  assign divHit = ((divQ & divMask) == divMask);

  generate
    if (USE_PRESCALER) begin : g_prescaler
      logic unusedLfTick;
      assign unusedLfTick = lfTick;
      always_comb begin
        divMask = '0;
        for (int i = 0; i < DIV_W; i++) divMask[i] = (i < int'(cfg));
      end
      assign tick = divHit;
    end else begin : g_source_sel
      always_comb begin
        divMask = '0;
        for (int i = 0; i < DIV_W; i++) divMask[i] = (i < FIXED_DIV_LOG);
      end
      assign tick = (|cfg) ? lfTick : divHit;
    end
  endgenerate

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter bit USE_PRESCALER = 1'b1,
  parameter int PSC_W         = 3,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wData,
  input  logic             extIn,
  input  logic             lfTick,
  output logic [7:0]       ctrlQ,
  output logic [CNT_W-1:0] preloadQ,
  output dpStrobe_t        stb
);
  localparam logic [7:0] CTRL_MASK = USE_PRESCALER ?
      8'((1 << (CTRL_CFG_LSB + PSC_W)) - 1) : 8'h1F;

  tmrMode_e mode;
  logic     edgeSel, runQ, runPrevQ, loadPulse, active;
  logic     intTick, rise, fall, evTick, startEv, stopEv;
  pwState_e pwQ, pwNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      preloadQ <= '0;
      runPrevQ <= 1'b0;
    end else begin
      runPrevQ <= runQ;
      if (wrEn && addr == ADDR_CTRL)    ctrlQ    <= wData[7:0] & CTRL_MASK;
      if (wrEn && addr == ADDR_PRELOAD) preloadQ <= wData;
    end
  end

  assign mode      = tmrMode_e'(ctrlQ[1:0]);
  assign edgeSel   = ctrlQ[CTRL_EDGE_BIT];
  assign runQ      = ctrlQ[CTRL_RUN_BIT];
  assign loadPulse = runQ & ~runPrevQ;
  assign active    = runQ & ~loadPulse;

  tmr_tick_gen #(
    .USE_PRESCALER(USE_PRESCALER),
    .PSC_W        (PSC_W),
    .FIXED_DIV_LOG(2)
  ) u_tick (
    .clk   (clk),
    .rstN  (rstN),
    .clear (~runQ | loadPulse),
    .cfg   (ctrlQ[CTRL_CFG_LSB +: PSC_W]),
    .lfTick(lfTick),
    .tick  (intTick)
  );

  tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(extIn),
    .riseOut(rise),
    .fallOut(fall)
  );

  assign evTick  = edgeSel ? fall : rise;
  assign startEv = edgeSel ? rise : fall;
  assign stopEv  = edgeSel ? fall : rise;

  always_comb begin
    pwNext = pwQ;
    if (!runQ || loadPulse) pwNext = PW_ARM;
    else begin
      case (pwQ)
        PW_ARM:  if (mode == MODE_PWIDTH && startEv) pwNext = PW_MEAS;
        PW_MEAS: if (stopEv) pwNext = PW_DONE;
        PW_DONE: pwNext = PW_DONE;
        default: pwNext = PW_ARM;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pwQ <= PW_ARM;
    else       pwQ <= pwNext;
  end

  always_comb begin
    stb.load    = loadPulse;
    stb.clrFlag = wrEn && (addr == ADDR_STATUS) && wData[0];
    case (mode)
      MODE_EVENT:  stb.inc = active & evTick;
      MODE_TIMER:  stb.inc = active & intTick;
      MODE_PWIDTH: stb.inc = active & intTick & (pwQ == PW_MEAS);
      default:     stb.inc = 1'b0;
    endcase
  end

  assert_stopped_no_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ || mode == MODE_IDLE) |-> !stb.inc)
    else $error("count strobe while stopped or idle");

  assert_load_on_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlQ[CTRL_RUN_BIT]) |-> (stb.load && !stb.inc))
    else $error("no load on run rising");

  assert_pw_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pwQ == PW_DONE && mode == MODE_PWIDTH) |-> !stb.inc)
    else $error("count after pulse measurement finished");

  assert_pw_done_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pwQ == PW_DONE && runQ) |=> (pwQ == PW_DONE || $past(loadPulse)))
    else $error("measurement rearmed without run toggle");

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] countQ,
  output logic             flagQ
);
  logic wrapNow;

  assign wrapNow = stb.inc && (countQ == '1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      flagQ  <= 1'b0;
    end else begin
      if (stb.load)     countQ <= preload;
      else if (stb.inc) countQ <= wrapNow ? preload : countQ + 1'b1;
      if (wrapNow && !stb.load) flagQ <= 1'b1;
      else if (stb.clrFlag)     flagQ <= 1'b0;
    end
  end

  assert_wrap_reload_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inc && !stb.load && countQ == '1) |=> (countQ == $past(preload) && flagQ))
    else $error("wrap did not reload and flag");

  assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !stb.clrFlag) |=> flagQ)
    else $error("flag dropped without clear");

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.inc && !stb.load) |=> $stable(countQ))
    else $error("count moved without strobe");

  assert_load_value_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (countQ == $past(preload)))
    else $error("load value wrong");

endmodule

// File: rtl/multimode_timer.sv
module multimode_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter bit USE_PRESCALER = 1'b1,
  parameter int PSC_W         = 3,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wData,
  output logic [CNT_W-1:0] rData,
  input  logic             extIn,
  input  logic             lfTick,
  output logic             ovfIrq
);
  logic [7:0]       ctrlQ;
  logic [CNT_W-1:0] preloadQ, countQ;
  logic             flagQ;
  dpStrobe_t        stb;

  tmr_ctrl #(
    .CNT_W        (CNT_W),
    .USE_PRESCALER(USE_PRESCALER),
    .PSC_W        (PSC_W),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .wData   (wData),
    .extIn   (extIn),
    .lfTick  (lfTick),
    .ctrlQ   (ctrlQ),
    .preloadQ(preloadQ),
    .stb     (stb)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .preload(preloadQ),
    .countQ (countQ),
    .flagQ  (flagQ)
  );

  always_comb begin
    case (addr)
      ADDR_CTRL:    rData = CNT_W'(ctrlQ);
      ADDR_PRELOAD: rData = preloadQ;
      ADDR_COUNT:   rData = countQ;
      default:      rData = CNT_W'(flagQ);
    endcase
  end

  assign ovfIrq = flagQ;

endmodule

// File: tb/tb_multimode_timer.sv
module tb_multimode_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wData = '0;
  logic        extIn = 1'b0;
  logic        lfTick = 1'b0;
  logic [15:0] rData, rDataAlt;
  logic        ovfIrq, ovfIrqAlt;
  int          nChecks = 0;
  int          nErr = 0;

  always #4 clk = ~clk;

  multimode_timer #(.USE_PRESCALER(1'b1)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wData(wData),
    .rData(rData), .extIn(extIn), .lfTick(lfTick), .ovfIrq(ovfIrq));

  multimode_timer #(.USE_PRESCALER(1'b0)) dutAlt (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wData(wData),
    .rData(rDataAlt), .extIn(extIn), .lfTick(lfTick), .ovfIrq(ovfIrqAlt));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; addr = a; wData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [15:0] d, output logic [15:0] dAlt);
    addr = a;
    #1;
    d = rData;
    dAlt = rDataAlt;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [15:0] v, vAlt, held;
    @(negedge clk);
    waitN(3);
    rstN = 1'b1;
    waitN(1);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      busRead(2'(a), v, vAlt);
      check("R1 reset reg", v, 16'h0);
      check("R1 reset reg alt", vAlt, 16'h0);
    end
    check("R1 irq", 16'(ovfIrq), 16'h0);

    // R2 readback of unused bits
    busWrite(2'd0, 16'h00FF);
    busRead(2'd0, v, vAlt);
    check("R2 ctrl prescaler variant", v, 16'h007F);
    check("R2 ctrl source variant", vAlt, 16'h001F);
    busWrite(2'd0, 16'h0000);
    waitN(2);

    // R7 idle mode with run set; R3 load on enable
    busWrite(2'd1, 16'd77);
    busWrite(2'd0, 16'h0008);
    waitN(50);
    busRead(2'd2, v, vAlt);
    check("R3 load on enable", v, 16'd77);
    check("R7 idle mode no count", vAlt, 16'd77);
    busWrite(2'd0, 16'h0000);

    // R4 / R5 timer sweep over all prescaler codes
    for (int n = 0; n < 8; n++) begin
      for (int mi = 0; mi < 4; mi++) begin
        int m;
        logic [15:0] p;
        m = (mi == 0) ? 3 : (mi == 1) ? 17 : (mi == 2) ? 64 : 131;
        p = 16'(20 + n);
        busWrite(2'd1, p);
        busWrite(2'd0, 16'(32'h0A | (n << 4)));
        waitN(m);
        busWrite(2'd0, 16'(32'h02 | (n << 4)));
        busRead(2'd2, v, vAlt);
        check("R4 timer prescale", v, 16'(int'(p) + (m >> n)));
        check("R5 alt source", vAlt, (n % 2 == 1) ? p : 16'(int'(p) + m / 4));
      end
    end

    // R7 count holds while run is clear
    busRead(2'd2, held, vAlt);
    waitN(30);
    busRead(2'd2, v, vAlt);
    check("R7 hold while stopped", v, held);

    // R5 low-frequency tick source
    for (int pi = 0; pi < 3; pi++) begin
      int np;
      int m;
      np = (pi == 0) ? 1 : (pi == 1) ? 4 : 9;
      m = 2 + 3 * np;
      busWrite(2'd1, 16'd300);
      busWrite(2'd0, 16'h001A);
      waitN(2);
      for (int k = 0; k < np; k++) begin
        lfTick = 1'b1;
        waitN(1);
        lfTick = 1'b0;
        waitN(2);
      end
      busWrite(2'd0, 16'h0012);
      busRead(2'd2, v, vAlt);
      check("R5 lf tick count", vAlt, 16'(300 + np));
      check("R4 div2 alongside", v, 16'(300 + m / 2));
    end

    // R6 event counting, both edges
    for (int e = 0; e < 2; e++) begin
      for (int k = 1; k <= 6; k++) begin
        busWrite(2'd1, 16'd100);
        busWrite(2'd0, (e == 1) ? 16'h000D : 16'h0009);
        waitN(4);
        for (int j = 0; j < k; j++) begin
          extIn = 1'b1; waitN(3);
          extIn = 1'b0; waitN(3);
        end
        extIn = 1'b1;
        waitN(5);
        busWrite(2'd0, 16'h0001);
        busRead(2'd2, v, vAlt);
        check((e == 1) ? "R6 falling edges" : "R6 rising edges", v,
              16'(100 + ((e == 1) ? k : k + 1)));
        extIn = 1'b0;
        waitN(5);
      end
    end

    // R8 / R10 pulse width, start on rising edge
    for (int wi = 0; wi < 4; wi++) begin
      int w;
      w = (wi == 0) ? 1 : (wi == 1) ? 2 : (wi == 2) ? 5 : 33;
      busWrite(2'd1, 16'd500);
      busWrite(2'd0, 16'h000F);
      waitN(4);
      extIn = 1'b1; waitN(w);
      extIn = 1'b0; waitN(6);
      busRead(2'd2, v, vAlt);
      check("R8 high pulse width", v, 16'(500 + w));
      extIn = 1'b1; waitN(3);
      extIn = 1'b0; waitN(6);
      busRead(2'd2, v, vAlt);
      check("R10 hold after stop", v, 16'(500 + w));
      busWrite(2'd0, 16'h0007);
      busWrite(2'd0, 16'h000F);
      waitN(2);
      busRead(2'd2, v, vAlt);
      check("R10 rearm reload", v, 16'd500);
      extIn = 1'b1; waitN(w + 3);
      extIn = 1'b0; waitN(6);
      busRead(2'd2, v, vAlt);
      check("R10 second measurement", v, 16'(500 + w + 3));
      busWrite(2'd0, 16'h0007);
    end

    // R9 pulse width, start on falling edge
    for (int wi = 0; wi < 3; wi++) begin
      int w;
      w = (wi == 0) ? 1 : (wi == 1) ? 7 : 40;
      extIn = 1'b1;
      waitN(5);
      busWrite(2'd1, 16'd900);
      busWrite(2'd0, 16'h000B);
      waitN(4);
      extIn = 1'b0; waitN(w);
      extIn = 1'b1; waitN(6);
      busRead(2'd2, v, vAlt);
      check("R9 low pulse width", v, 16'(900 + w));
      busWrite(2'd0, 16'h0003);
      extIn = 1'b0;
      waitN(5);
    end

    // R11 overflow and R12 clear
    busWrite(2'd1, 16'hFFF0);
    busWrite(2'd0, 16'h000A);
    waitN(40);
    busWrite(2'd0, 16'h0002);
    busRead(2'd2, v, vAlt);
    check("R11 wrap reload", v, 16'(32'hFFF0 + (40 % 16)));
    busRead(2'd3, v, vAlt);
    check("R11 flag set", v, 16'h0001);
    check("R11 irq high", 16'(ovfIrq), 16'h0001);
    busWrite(2'd3, 16'h0000);
    busRead(2'd3, v, vAlt);
    check("R12 write zero keeps flag", v, 16'h0001);
    busWrite(2'd3, 16'h0001);
    busRead(2'd3, v, vAlt);
    check("R12 clear flag", v, 16'h0000);
    check("R12 irq low", 16'(ovfIrq), 16'h0000);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule